// File: doc/BRIEF.md
# Pad Input Event Router

This block sits between the per-pad input event detectors and the places that consume those events. Every pad has a 2-bit owner code and a host driver-mode select. When a pad's event strobe fires, the block looks at that pad's current owner. If the host owns the pad, the event sets sticky host status bits. In driver mode only the general input status bit is set. In the other host mode the GPE, NMI and SMI status bits are set, each one only when its own enable is on. If an implemented agent owns the pad, every host status bit for that pad is masked. When notification is enabled for the pad, the block instead queues a message for the owning agent.

Host software clears status bits by writing ones to them. A new event that arrives in the same cycle as the clear takes priority. Outgoing messages carry the pad index and the destination code. They wait in a small FIFO until the sideband transport accepts them. Events on several pads in one cycle enter the FIFO lowest pad first. Messages that find no room are dropped and raise a sticky overflow flag.

Top module: `pad_event_router`

## Requirements
- R1: With owner 00 and driver mode selected, an event sets only the pad's general status bit. The GPE, NMI and SMI bits are left unchanged whatever their enables are.
- R2: With owner 00 and driver mode not selected, an event sets the pad's GPE, NMI and SMI status bits, each only when its own enable is 1. The general status bit is left unchanged.
- R3: With an implemented agent as owner (01, 10 or 11), an event sets none of the pad's four host status bits.
- R4: With an implemented agent as owner and notification enabled, an event queues exactly one message with msg_pad_o equal to the pad index and msg_dest_o equal to the owner code. With notification disabled, no message is queued.
- R5: While the host owns a pad, an event on it queues no message, even when notification is enabled.
- R6: Bit k of parameter AGENTS_PRESENT marks owner code k+1 as implemented. An owner code whose bit is 0 is reserved and routes events exactly like 00.
- R7: Host status bits are sticky. Writing 1 to a bit of a clear input for one cycle clears that bit. An event in the same cycle as the clear leaves the bit set.
- R8: The message FIFO holds FIFO_DEPTH entries. The head is held on msg_pad_o/msg_dest_o while msg_valid_o is 1, and it is popped on a cycle with msg_ready_i at 1. A message that finds the FIFO full is dropped and sets ovf_o, which stays 1 until reset.
- R9: Messages raised by several pads in the same cycle are queued in ascending pad-index order.
- R10: After reset, all status bits, msg_valid_o and ovf_o are 0.
- R11: Status bits and queued messages become visible on the outputs in the cycle after the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_PADS | Per-pad input event strobe |
| owner_i | input | 2*NUM_PADS | Owner code of pad i at bits [2i+1:2i] |
| drv_mode_i | input | NUM_PADS | Host driver-mode select per pad |
| notify_en_i | input | NUM_PADS | Agent notification enable per pad |
| gpe_en_i | input | NUM_PADS | GPE status enable per pad |
| nmi_en_i | input | NUM_PADS | NMI status enable per pad |
| smi_en_i | input | NUM_PADS | SMI status enable per pad |
| gen_clr_i | input | NUM_PADS | Write-1-to-clear for general status |
| gpe_clr_i | input | NUM_PADS | Write-1-to-clear for GPE status |
| nmi_clr_i | input | NUM_PADS | Write-1-to-clear for NMI status |
| smi_clr_i | input | NUM_PADS | Write-1-to-clear for SMI status |
| gen_sts_o | output | NUM_PADS | General input status |
| gpe_sts_o | output | NUM_PADS | GPE status |
| nmi_sts_o | output | NUM_PADS | NMI status |
| smi_sts_o | output | NUM_PADS | SMI status |
| msg_valid_o | output | 1 | FIFO head holds a message |
| msg_pad_o | output | $clog2(NUM_PADS) | Pad index of the head message |
| msg_dest_o | output | 2 | Destination agent code of the head message |
| msg_ready_i | input | 1 | Transport accepts the head message |
| ovf_o | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench builds the block with eight pads, a four-entry FIFO and AGENTS_PRESENT = 3'b011. With these values, owner code 11 is a reserved code, so the fallback to host routing can be observed at the ports next to real agent codes 01 and 10. Six agent pads firing in one cycle exceed the four free slots, which makes the ascending-order fill and the drop-with-overflow path both observable in a single event. Eight pads also leave spare pads, so the bench can show that one pad's routing does not disturb the status of another.

// File: rtl/pev_pkg.sv
// Package: shared owner encoding and the agent-validity helper.
// Assumes owner codes are 2 bits wide; code 00 always means host.
package pev_pkg;

    typedef enum logic [1:0] {
        OWN_HOST = 2'b00,
        OWN_AG1  = 2'b01,
        OWN_AG2  = 2'b10,
        OWN_AG3  = 2'b11
    } owner_e;

    // True when the code names an agent that the build implements.
    function automatic logic agent_valid(input logic [1:0] code, input logic [2:0] present);
        logic ok;
        case (code)
            OWN_AG1: ok = present[0];
            OWN_AG2: ok = present[1];
            OWN_AG3: ok = present[2];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pev_decode.sv
// Module: per-pad steering of one event strobe to host status classes or
// to an agent notification request. Purely combinational.
// Assumes: owner codes whose agent is absent are handled as host-owned.
module pev_decode #(
    parameter int       NUM_PADS       = 8,
    parameter bit [2:0] AGENTS_PRESENT = 3'b111
) (
    input  logic [NUM_PADS-1:0]   evt,
    input  logic [2*NUM_PADS-1:0] owner,
    input  logic [NUM_PADS-1:0]   drv_mode,
    input  logic [NUM_PADS-1:0]   notify_en,
    input  logic [NUM_PADS-1:0]   gpe_en,
    input  logic [NUM_PADS-1:0]   nmi_en,
    input  logic [NUM_PADS-1:0]   smi_en,
    output logic [NUM_PADS-1:0]   agent_own,
    output logic [NUM_PADS-1:0]   gen_set,
    output logic [NUM_PADS-1:0]   gpe_set,
    output logic [NUM_PADS-1:0]   nmi_set,
    output logic [NUM_PADS-1:0]   smi_set,
    output logic [NUM_PADS-1:0]   notify_req,
    output logic [2*NUM_PADS-1:0] dest
);
    import pev_pkg::*;

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        logic [1:0] code;
        logic       host_evt;

        // Classify the pad's owner and split its event into routes.
        always_comb begin
            code            = owner[2*i +: 2];
            agent_own[i]    = agent_valid(code, AGENTS_PRESENT);
            host_evt        = evt[i] & ~agent_own[i];
            gen_set[i]      = host_evt &  drv_mode[i];
            gpe_set[i]      = host_evt & ~drv_mode[i] & gpe_en[i];
            nmi_set[i]      = host_evt & ~drv_mode[i] & nmi_en[i];
            smi_set[i]      = host_evt & ~drv_mode[i] & smi_en[i];
            notify_req[i]   = evt[i] & agent_own[i] & notify_en[i];
            dest[2*i +: 2]  = agent_own[i] ? code : OWN_HOST;
        end
    end

endmodule

// File: rtl/pev_status.sv
// Module: one class of sticky host status bits with write-1-to-clear.
// Assumes: set and clear are single-cycle strobes; set has priority.
module pev_status #(
    parameter int NUM_PADS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] set,
    input  logic [NUM_PADS-1:0] clr,
    output logic [NUM_PADS-1:0] sts
);

    // Hold, clear on write-1, and let a same-cycle event win.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~clr) | set;
    end

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> sts[i]); // R7
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !sts[i]); // R7
    end

endmodule

// File: rtl/pev_notify_fifo.sv
// Module: notification queue that accepts several requests per cycle,
// packing them lowest pad first; requests with no room are dropped and
// flagged in a sticky overflow bit.
// Assumes: DEPTH is a power of two and at least 2.
module pev_notify_fifo #(
    parameter int NUM_PADS = 8,
    parameter int DEPTH    = 4,
    parameter int IDXW     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PADS-1:0]   req,
    input  logic [2*NUM_PADS-1:0] req_dest,
    input  logic                  ready,
    output logic                  valid,
    output logic [IDXW-1:0]       head_pad,
    output logic [1:0]            head_dest,
    output logic                  ovf
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [IDXW-1:0] mem_pad  [DEPTH];
    logic [1:0]      mem_dest [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;
    logic [CW-1:0]   count;

    logic            pop;
    logic [CW-1:0]   free_slots;
    logic [CW-1:0]   n_push;
    logic            drop;
    logic [PW-1:0]   wr_idx;
    logic            slot_we   [DEPTH];
    logic [IDXW-1:0] slot_pad  [DEPTH];
    logic [1:0]      slot_dest [DEPTH];

    // Head of queue view.
    always_comb begin
        valid     = (count != '0);
        head_pad  = mem_pad[rd_ptr];
        head_dest = mem_dest[rd_ptr];
        pop       = valid & ready;
    end

    // Pack this cycle's requests into free slots in ascending pad order.
    always_comb begin
        free_slots = CW'(DEPTH) - count + CW'(pop);
        n_push     = '0;
        drop       = 1'b0;
        wr_idx     = '0;
        for (int d = 0; d < DEPTH; d++) begin
            slot_we[d]   = 1'b0;
            slot_pad[d]  = '0;
            slot_dest[d] = '0;
        end
        for (int i = 0; i < NUM_PADS; i++) begin
            if (req[i]) begin
                if (n_push < free_slots) begin
                    wr_idx            = wr_ptr + n_push[PW-1:0];
                    slot_we[wr_idx]   = 1'b1;
                    slot_pad[wr_idx]  = IDXW'(i);
                    slot_dest[wr_idx] = req_dest[2*i +: 2];
                    n_push            = n_push + 1'b1;
                end else begin
                    drop = 1'b1;
                end
            end
        end
    end

    // Store the packed entries.
    always_ff @(posedge clk) begin
        for (int d = 0; d < DEPTH; d++) begin
            if (slot_we[d]) begin
                mem_pad[d]  <= slot_pad[d];
                mem_dest[d] <= slot_dest[d];
            end
        end
    end

    // Advance pointers, occupancy and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            rd_ptr <= rd_ptr + PW'(pop);
            wr_ptr <= wr_ptr + n_push[PW-1:0];
            count  <= count + n_push - CW'(pop);
            ovf    <= ovf | drop;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R8
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(head_pad) && $stable(head_dest))); // R8

endmodule

// File: rtl/pad_event_router.sv
// Module: top of the pad input event router. Decodes each pad's owner,
// updates four sticky host status classes and queues agent notifications.
// Assumes: evt_i is already a one-cycle strobe per detected pad event.
module pad_event_router #(
    parameter int       NUM_PADS       = 8,
    parameter int       FIFO_DEPTH     = 4,
    parameter bit [2:0] AGENTS_PRESENT = 3'b111,
    parameter int       IDXW           = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PADS-1:0]   evt_i,
    input  logic [2*NUM_PADS-1:0] owner_i,
    input  logic [NUM_PADS-1:0]   drv_mode_i,
    input  logic [NUM_PADS-1:0]   notify_en_i,
    input  logic [NUM_PADS-1:0]   gpe_en_i,
    input  logic [NUM_PADS-1:0]   nmi_en_i,
    input  logic [NUM_PADS-1:0]   smi_en_i,
    input  logic [NUM_PADS-1:0]   gen_clr_i,
    input  logic [NUM_PADS-1:0]   gpe_clr_i,
    input  logic [NUM_PADS-1:0]   nmi_clr_i,
    input  logic [NUM_PADS-1:0]   smi_clr_i,
    output logic [NUM_PADS-1:0]   gen_sts_o,
    output logic [NUM_PADS-1:0]   gpe_sts_o,
    output logic [NUM_PADS-1:0]   nmi_sts_o,
    output logic [NUM_PADS-1:0]   smi_sts_o,
    output logic                  msg_valid_o,
    output logic [IDXW-1:0]       msg_pad_o,
    output logic [1:0]            msg_dest_o,
    input  logic                  msg_ready_i,
    output logic                  ovf_o
);

    logic [NUM_PADS-1:0]   agent_own;
    logic [NUM_PADS-1:0]   gen_set, gpe_set, nmi_set, smi_set;
    logic [NUM_PADS-1:0]   notify_req;
    logic [2*NUM_PADS-1:0] dest;

    pev_decode #(
        .NUM_PADS       (NUM_PADS),
        .AGENTS_PRESENT (AGENTS_PRESENT)
    ) u_decode (
        .evt        (evt_i),
        .owner      (owner_i),
        .drv_mode   (drv_mode_i),
        .notify_en  (notify_en_i),
        .gpe_en     (gpe_en_i),
        .nmi_en     (nmi_en_i),
        .smi_en     (smi_en_i),
        .agent_own  (agent_own),
        .gen_set    (gen_set),
        .gpe_set    (gpe_set),
        .nmi_set    (nmi_set),
        .smi_set    (smi_set),
        .notify_req (notify_req),
        .dest       (dest)
    );

    pev_status #(.NUM_PADS(NUM_PADS)) u_gen_sts (
        .clk (clk), .rst_n (rst_n), .set (gen_set), .clr (gen_clr_i), .sts (gen_sts_o));
    pev_status #(.NUM_PADS(NUM_PADS)) u_gpe_sts (
        .clk (clk), .rst_n (rst_n), .set (gpe_set), .clr (gpe_clr_i), .sts (gpe_sts_o));
    pev_status #(.NUM_PADS(NUM_PADS)) u_nmi_sts (
        .clk (clk), .rst_n (rst_n), .set (nmi_set), .clr (nmi_clr_i), .sts (nmi_sts_o));
    pev_status #(.NUM_PADS(NUM_PADS)) u_smi_sts (
        .clk (clk), .rst_n (rst_n), .set (smi_set), .clr (smi_clr_i), .sts (smi_sts_o));

    pev_notify_fifo #(
        .NUM_PADS (NUM_PADS),
        .DEPTH    (FIFO_DEPTH),
        .IDXW     (IDXW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (notify_req),
        .req_dest  (dest),
        .ready     (msg_ready_i),
        .valid     (msg_valid_o),
        .head_pad  (msg_pad_o),
        .head_dest (msg_dest_o),
        .ovf       (ovf_o)
    );

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_chk
        AST_AGENT_MASKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && agent_own[i] && !(gen_sts_o[i] || gpe_sts_o[i] || nmi_sts_o[i] || smi_sts_o[i]))
            |=> !(gen_sts_o[i] || gpe_sts_o[i] || nmi_sts_o[i] || smi_sts_o[i])); // R3
        AST_DRV_ONLY_GEN: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && !agent_own[i] && drv_mode_i[i] && !gpe_sts_o[i] && !nmi_sts_o[i] && !smi_sts_o[i])
            |=> (!gpe_sts_o[i] && !nmi_sts_o[i] && !smi_sts_o[i])); // R1
        AST_ACPI_NO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && !agent_own[i] && !drv_mode_i[i] && !gen_sts_o[i]) |=> !gen_sts_o[i]); // R2
    end

    AST_HOST_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & agent_own) == '0 && !msg_valid_o) |=> !msg_valid_o); // R5
    AST_DEST_IS_AGENT: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_dest_o != 2'b00)); // R4

endmodule

// File: tb/pad_event_router_tb.sv
module pad_event_router_tb;
    localparam int N = 8;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0, drv = '0, nen = '1, gen = '1, nen_m = '1, sen = '1;
    logic [N-1:0] gclr = '0, pclr = '0, mclr = '0, sclr = '0;
    logic [2*N-1:0] own = '0;
    logic [N-1:0] gsts, psts, msts, ssts;
    logic         mvalid, ready = 1'b0, ovf;
    logic [W-1:0] mpad;
    logic [1:0]   mdest;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pad_event_router #(.NUM_PADS(N), .FIFO_DEPTH(4), .AGENTS_PRESENT(3'b011)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .owner_i(own), .drv_mode_i(drv),
        .notify_en_i(nen), .gpe_en_i(gen), .nmi_en_i(nen_m), .smi_en_i(sen),
        .gen_clr_i(gclr), .gpe_clr_i(pclr), .nmi_clr_i(mclr), .smi_clr_i(sclr),
        .gen_sts_o(gsts), .gpe_sts_o(psts), .nmi_sts_o(msts), .smi_sts_o(ssts),
        .msg_valid_o(mvalid), .msg_pad_o(mpad), .msg_dest_o(mdest),
        .msg_ready_i(ready), .ovf_o(ovf));

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pulse events for one cycle; results are sampled at the following negedge.
    task automatic fire(input logic [N-1:0] m);
        @(negedge clk) evt = m;
        @(negedge clk) evt = '0;
    endtask

    task automatic set_own(input int p, input logic [1:0] c);
        own[2*p +: 2] = c;
    endtask

    task automatic clear_all();
        @(negedge clk) begin gclr = '1; pclr = '1; mclr = '1; sclr = '1; end
        @(negedge clk) begin gclr = '0; pclr = '0; mclr = '0; sclr = '0; end
    endtask

    // Check head message then pop it.
    task automatic pop_expect(input int pad, input int dst, input string tag);
        check(mvalid, 1, {tag, " valid"});
        check(mpad, pad, {tag, " pad"});
        check(mdest, dst, {tag, " dest"});
        ready = 1'b1;
        @(negedge clk) ready = 1'b0;
    endtask

    task automatic t_reset();
        check({gsts, psts, msts, ssts}, 0, "R10 status after reset");
        check(mvalid, 0, "R10 msg_valid after reset");
        check(ovf, 0, "R10 ovf after reset");
    endtask

    task automatic t_driver_mode();
        drv = 8'h04;
        fire(8'h04);
        check(gsts, 8'h04, "R1 R11 general status set");
        check({psts, msts, ssts}, 0, "R1 other classes untouched");
        check(mvalid, 0, "R5 host pad gives no message");
    endtask

    task automatic t_acpi_mode();
        nen_m = 8'h00;
        fire(8'h08);
        check(psts, 8'h08, "R2 gpe set");
        check(msts, 8'h00, "R2 nmi gated by enable");
        check(ssts, 8'h08, "R2 smi set");
        check(gsts, 8'h04, "R2 general unchanged, R7 sticky");
        check(mvalid, 0, "R5 host pad gives no message");
        nen_m = '1;
    endtask

    task automatic t_clear();
        @(negedge clk) pclr = 8'h08;
        @(negedge clk) pclr = 8'h00;
        check(psts, 8'h00, "R7 gpe cleared by write 1");
        check(ssts, 8'h08, "R7 smi kept");
        @(negedge clk) begin evt = 8'h08; pclr = 8'h08; end
        @(negedge clk) begin evt = 8'h00; pclr = 8'h00; end
        check(psts, 8'h08, "R7 set wins over clear");
        clear_all();
        check({gsts, psts, msts, ssts}, 0, "R7 all cleared");
    endtask

    task automatic t_agent();
        set_own(5, 2'b01);
        set_own(6, 2'b10);
        nen = 8'hBF;
        drv = 8'h00;
        fire(8'h60);
        check({gsts, psts, msts, ssts}, 0, "R3 agent pads set no host status");
        pop_expect(5, 1, "R4 agent message");
        check(mvalid, 0, "R4 disabled pad queues nothing");
        nen = '1;
        set_own(5, 2'b00);
        set_own(6, 2'b00);
    endtask

    task automatic t_reserved();
        set_own(1, 2'b11);
        drv = 8'h02;
        fire(8'h02);
        check(gsts, 8'h02, "R6 reserved code routes as host");
        check(mvalid, 0, "R6 reserved code sends no message");
        set_own(1, 2'b00);
        drv = 8'h00;
        clear_all();
    endtask

    task automatic t_order();
        set_own(7, 2'b10);
        set_own(4, 2'b01);
        set_own(0, 2'b10);
        fire(8'h91);
        pop_expect(0, 2, "R9 first");
        pop_expect(4, 1, "R9 second");
        pop_expect(7, 2, "R9 third");
        check(mvalid, 0, "R9 drained");
        check(ovf, 0, "R8 no overflow within depth");
        own = '0;
    endtask

    task automatic t_overflow();
        for (int p = 0; p < 6; p++) set_own(p, (p % 2 == 0) ? 2'b01 : 2'b10);
        fire(8'h3F);
        check(ovf, 1, "R8 overflow flag set");
        check({gsts, psts, msts, ssts}, 0, "R3 no host status on overflow burst");
        repeat (3) @(negedge clk);
        check(mvalid, 1, "R8 head held while not ready");
        check(mpad, 0, "R8 head pad held");
        for (int p = 0; p < 4; p++) pop_expect(p, (p % 2 == 0) ? 1 : 2, "R8 R9 kept entry");
        check(mvalid, 0, "R8 extra entries dropped");
        check(ovf, 1, "R8 overflow sticky");
        own = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_driver_mode();
        t_acpi_mode();
        t_clear();
        t_agent();
        t_reserved();
        t_order();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule